// File: doc/BRIEF.md
# Operand Address Sequencer

This block runs the bus cycles of an 8-bit processor from the cycle after the opcode fetch until the operand byte is in hand. The core pulses `start_i` during the opcode fetch cycle. With that pulse it presents the addressing-mode code, both index registers and the program counter, which already points past the opcode. From the next cycle on, the sequencer drives one read address per cycle and captures the returned byte at each clock edge. It keeps its own copy of the program counter and a working high:low address pair.

The sequencer issues the discarded reads and the conditional extra cycle exactly as the target machine does. A low-byte index add that carries costs one more cycle with a corrected high byte. Zero-page arithmetic wraps inside page 0. The indirect jump increments its pointer without carrying into the pointer's high byte. The bus is read-only here. Stores, arithmetic and flags belong to other blocks.

Top module: `opaddr_seq`

## Requirements
- R1: After reset, `rd_o` and `done_o` are 0. `rd_o` is 1 in every cycle from the cycle after an accepted `start_i` through the final bus cycle, and is 0 otherwise.
- R2: Mode codes 0, 1 and 12–15 (implied-like) use one bus cycle. It reads at PC, and the PC is left unchanged.
- R3: Mode 2 (immediate) uses one bus cycle. It reads at PC, and the final PC is PC+1.
- R4: Mode 3 (zero page) uses two bus cycles: first PC, then 0x00:b, where b is the byte read at PC. The final PC is PC+1.
- R5: Modes 4 (index X) and 5 (index Y) of zero page use three bus cycles: PC, then the discarded 0x00:b, then 0x00:((b+index) mod 256). The final PC is PC+1.
- R6: Mode 6 (absolute) uses three bus cycles: PC, PC+1, then hi:lo. The final PC is PC+2.
- R7: Modes 7 (X) and 8 (Y) of absolute indexed read PC, PC+1, then hi:((lo+index) mod 256). If lo+index exceeds 255, a fourth read follows at (hi+1):((lo+index) mod 256). The final PC is PC+2.
- R8: Mode 9 (pre-indexed indirect) uses five bus cycles: PC, the discarded 0x00:b, 0x00:p, 0x00:(p+1) and the pointer target. Here p = (b+X) mod 256, and all zero-page steps wrap. The final PC is PC+1.
- R9: Mode 10 (post-indexed indirect) reads PC, 0x00:b and 0x00:(b+1 mod 256). It then reads hi:((lo+Y) mod 256). A fifth read at the incremented high byte follows only when lo+Y exceeds 255. The final PC is PC+1.
- R10: Mode 11 (indirect jump) uses four bus cycles: PC, PC+1, ph:pl and ph:((pl+1) mod 256). The final PC is the two target bytes read, low byte first.
- R11: `done_o` is high for exactly the one cycle after the final bus cycle. In that cycle, `operand_o` holds the byte returned by the final read, and `pc_o` holds the final PC.
- R12: `start_i` is ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence (opcode fetch cycle) |
| mode_i | input | 4 | Addressing-mode code |
| x_i | input | DW | X index register |
| y_i | input | DW | Y index register |
| pc_i | input | AW | PC pointing past the opcode |
| rdata_i | input | DW | Read data for the current bus address |
| addr_o | output | AW | Bus address of the current cycle |
| rd_o | output | 1 | Read strobe |
| done_o | output | 1 | One-cycle completion pulse |
| operand_o | output | DW | Byte from the final read |
| pc_o | output | AW | Current program counter |
| work_addr_o | output | AW | Working high:low address pair |

## Verification
The bench builds the default DW = 8, which gives the full 16-bit address space. This keeps every byte-wide add small enough to wrap. Index values 0x00, 0x01, 0x7F, 0x80 and 0xFF, each paired with three program counters, sweep all twelve modes against an arithmetic trace model. The program counters include one at 0xFFFF. This reaches both carry and no-carry outcomes of the indexed modes and PC wrap-around. Patched memory bytes force the pointer at 0x02FF, a zero-page pointer straddling 0xFF/0x00 and guaranteed page crossings.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  localparam int MODE_W = 4;
  typedef enum logic [MODE_W-1:0] {
    M_IMP  = 4'd0,  M_ACC  = 4'd1,  M_IMM  = 4'd2,  M_ZP   = 4'd3,
    M_ZPX  = 4'd4,  M_ZPY  = 4'd5,  M_ABS  = 4'd6,  M_ABSX = 4'd7,
    M_ABSY = 4'd8,  M_IZX  = 4'd9,  M_IZY  = 4'd10, M_IND  = 4'd11
  } mode_e;
  localparam int CYC_W = 3;
endpackage

// File: rtl/opaddr_add.sv
module opaddr_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  assign {co_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/opaddr_ctrl.sv
module opaddr_ctrl
  import opaddr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             last_i,
  output logic             busy_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cyc_q  <= '0;
    end else begin
      done_q <= busy_q & last_i;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cyc_q  <= CYC_W'(2);
        end
      end else if (last_i) begin
        busy_q <= 1'b0;
        cyc_q  <= '0;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign cyc_o  = cyc_q;
  assign done_o = done_q;
endmodule

// File: rtl/opaddr_seq.sv
module opaddr_seq
  import opaddr_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     y_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DW-1:0]     rdata_i,
  output logic [AW-1:0]     addr_o,
  output logic              rd_o,
  output logic              done_o,
  output logic [DW-1:0]     operand_o,
  output logic [AW-1:0]     pc_o,
  output logic [AW-1:0]     work_addr_o
);
  mode_e            mode_q;
  logic [DW-1:0]    idx_q, adl_q, adh_q, ial_q, dl_q;
  logic [DW-1:0]    adl_d, adh_d, ial_d, dl_d;
  logic [AW-1:0]    pc_q, pc_d, addr;
  logic             cl_q, cl_d, last, busy;
  logic [CYC_W-1:0] cyc_w;
  logic [DW-1:0]    add_a, add_b, add_sum, hi_inc;
  logic             add_co, hi_co;
  logic [AW-1:0]    zp_addr, wk_addr, pc_inc;

  opaddr_ctrl u_ctrl (
    .clk_i (clk_i), .rst_ni(rst_ni), .start_i(start_i), .last_i(last),
    .busy_o(busy), .cyc_o(cyc_w), .done_o(done_o)
  );

  opaddr_add #(.W(DW)) u_lo_add (
    .a_i(add_a), .b_i(add_b), .sum_o(add_sum), .co_o(add_co)
  );

  opaddr_add #(.W(DW)) u_hi_add (
    .a_i(adh_q), .b_i(DW'(1)), .sum_o(hi_inc), .co_o(hi_co)
  );

  assign zp_addr = {{DW{1'b0}}, adl_q};
  assign wk_addr = {adh_q, adl_q};
  assign pc_inc  = pc_q + 1'b1;

  always_comb begin
    addr  = pc_q;
    last  = 1'b0;
    pc_d  = pc_q;
    adl_d = adl_q;
    adh_d = adh_q;
    ial_d = ial_q;
    cl_d  = cl_q;
    dl_d  = dl_q;
    add_a = adl_q;
    add_b = idx_q;
    if (busy) begin
      if (cyc_w == CYC_W'(2)) begin
        // shared operand-byte fetch at PC
        unique case (mode_q)
          M_IMM: begin pc_d = pc_inc; last = 1'b1; end
          M_ZP, M_ZPX, M_ZPY, M_IZX, M_IZY: begin
            adl_d = rdata_i; adh_d = '0; pc_d = pc_inc;
          end
          M_ABS, M_ABSX, M_ABSY, M_IND: begin adl_d = rdata_i; pc_d = pc_inc; end
          default: last = 1'b1;
        endcase
      end else begin
        unique case (mode_q)
          M_ZP: begin addr = zp_addr; last = 1'b1; end
          M_ZPX, M_ZPY: begin
            addr = zp_addr;
            if (cyc_w == CYC_W'(3)) adl_d = add_sum;
            else last = 1'b1;
          end
          M_ABS, M_ABSX, M_ABSY: begin
            if (cyc_w == CYC_W'(3)) begin
              adh_d = rdata_i; pc_d = pc_inc;
              if (mode_q != M_ABS) begin adl_d = add_sum; cl_d = add_co; end
            end else begin
              addr = wk_addr;
              if (cyc_w == CYC_W'(4) && mode_q != M_ABS && cl_q) adh_d = hi_inc;
              else last = 1'b1;
            end
          end
          M_IZX: begin
            unique case (cyc_w)
              CYC_W'(3): begin addr = zp_addr; adl_d = add_sum; end
              CYC_W'(4): begin addr = zp_addr; ial_d = rdata_i; add_b = DW'(1); adl_d = add_sum; end
              CYC_W'(5): begin addr = zp_addr; adh_d = rdata_i; adl_d = ial_q; end
              default:   begin addr = wk_addr; last = 1'b1; end
            endcase
          end
          M_IZY: begin
            unique case (cyc_w)
              CYC_W'(3): begin addr = zp_addr; ial_d = rdata_i; add_b = DW'(1); adl_d = add_sum; end
              CYC_W'(4): begin
                addr = zp_addr; adh_d = rdata_i; add_a = ial_q; adl_d = add_sum; cl_d = add_co;
              end
              CYC_W'(5): begin
                addr = wk_addr;
                if (cl_q) adh_d = hi_inc;
                else last = 1'b1;
              end
              default:   begin addr = wk_addr; last = 1'b1; end
            endcase
          end
          M_IND: begin
            unique case (cyc_w)
              CYC_W'(3): begin adh_d = rdata_i; pc_d = pc_inc; end
              // pointer low increments with no carry into the high byte
              CYC_W'(4): begin
                addr = wk_addr; pc_d = {pc_q[AW-1:DW], rdata_i}; add_b = DW'(1); adl_d = add_sum;
              end
              default: begin addr = wk_addr; pc_d = {rdata_i, pc_q[DW-1:0]}; last = 1'b1; end
            endcase
          end
          default: last = 1'b1;
        endcase
      end
      if (last) dl_d = rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_IMP;
      idx_q  <= '0;
      pc_q   <= '0;
      adl_q  <= '0;
      adh_q  <= '0;
      ial_q  <= '0;
      dl_q   <= '0;
      cl_q   <= 1'b0;
    end else if (!busy) begin
      if (start_i) begin
        mode_q <= mode_e'(mode_i);
        idx_q  <= (mode_e'(mode_i) inside {M_ZPY, M_ABSY, M_IZY}) ? y_i : x_i;
        pc_q   <= pc_i;
        cl_q   <= 1'b0;
      end
    end else begin
      pc_q  <= pc_d;
      adl_q <= adl_d;
      adh_q <= adh_d;
      ial_q <= ial_d;
      dl_q  <= dl_d;
      cl_q  <= cl_d;
    end
  end

  assign addr_o      = addr;
  assign rd_o        = busy;
  assign operand_o   = dl_q;
  assign pc_o        = pc_q;
  assign work_addr_o = wk_addr;
endmodule

// File: rtl/opaddr_seq_chk.sv
module opaddr_seq_chk
  import opaddr_pkg::*;
#(
  parameter int AW = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_o,
  input logic             done_o,
  input logic [AW-1:0]    addr_o,
  input logic [AW-1:0]    pc_o,
  input mode_e            mode_q,
  input logic [CYC_W-1:0] cyc_w
);
  localparam int HW = AW / 2;

  p_done_after_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(rd_o) && !rd_o));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_imp_pc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && mode_q inside {M_IMP, M_ACC}) |=> $stable(pc_o));

  p_zp_page0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && mode_q inside {M_ZP, M_ZPX, M_ZPY} && cyc_w >= CYC_W'(3))
      |-> addr_o[AW-1:HW] == '0);

  p_abs_cross_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && mode_q inside {M_ABSX, M_ABSY} && cyc_w == CYC_W'(5))
      |-> (addr_o[HW-1:0] == $past(addr_o[HW-1:0]) &&
           addr_o[AW-1:HW] == HW'($past(addr_o[AW-1:HW]) + 1'b1)));

  p_ind_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && mode_q == M_IND && cyc_w == CYC_W'(5))
      |-> (addr_o[AW-1:HW] == $past(addr_o[AW-1:HW]) &&
           addr_o[HW-1:0] == HW'($past(addr_o[HW-1:0]) + 1'b1)));
endmodule

bind opaddr_seq opaddr_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_o(rd_o), .done_o(done_o),
  .addr_o(addr_o), .pc_o(pc_o), .mode_q(mode_q), .cyc_w(cyc_w)
);

// File: tb/tb_opaddr_seq.sv
module tb_opaddr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [7:0]  x_i = '0, y_i = '0, rdata_i;
  logic [15:0] pc_i = '0;
  logic [15:0] addr_o, pc_o, work_addr_o;
  logic        rd_o, done_o;
  logic [7:0]  operand_o;
  int checks = 0, errors = 0;

  logic [15:0] pa [8];
  logic [7:0]  pd [8];
  int          pn = 0;

  always #4 clk = ~clk;

  opaddr_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i),
    .x_i(x_i), .y_i(y_i), .pc_i(pc_i), .rdata_i(rdata_i),
    .addr_o(addr_o), .rd_o(rd_o), .done_o(done_o), .operand_o(operand_o),
    .pc_o(pc_o), .work_addr_o(work_addr_o)
  );

  function automatic logic [7:0] memr(input logic [15:0] a);
    logic [15:0] t;
    for (int i = 0; i < 8; i++)
      if (i < pn && pa[i] == a) return pd[i];
    t = a * 16'd29;
    return t[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_comb rdata_i = memr(addr_o);

  function automatic string tag(input logic [3:0] m);
    case (m)
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6: return "R6";
      4'd7, 4'd8: return "R7";
      4'd9: return "R8";
      4'd10: return "R9";
      4'd11: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input logic [3:0] m, input logic [15:0] pc,
                          input logic [7:0] x, input logic [7:0] y, input bit poke);
    logic [15:0] e [6];
    logic [15:0] epc;
    logic [7:0]  b, lo, hi, p, ix, tl, th;
    logic [8:0]  s;
    int n;
    epc = pc + 16'd1;
    b = memr(pc);
    lo = b;
    hi = memr(pc + 16'd1);
    e[0] = pc;
    ix = (m == 4'd5 || m == 4'd8 || m == 4'd10) ? y : x;
    case (m)
      4'd2: n = 1;
      4'd3: begin e[1] = {8'h00, b}; n = 2; end
      4'd4, 4'd5: begin e[1] = {8'h00, b}; e[2] = {8'h00, 8'(b + ix)}; n = 3; end
      4'd6, 4'd7, 4'd8: begin
        s = {1'b0, lo} + ((m == 4'd6) ? 9'd0 : {1'b0, ix});
        e[1] = pc + 16'd1; e[2] = {hi, s[7:0]}; n = 3; epc = pc + 16'd2;
        if (s[8]) begin e[3] = {8'(hi + 8'd1), s[7:0]}; n = 4; end
      end
      4'd9: begin
        p = b + x; lo = memr({8'h00, p}); hi = memr({8'h00, 8'(p + 8'd1)});
        e[1] = {8'h00, b}; e[2] = {8'h00, p}; e[3] = {8'h00, 8'(p + 8'd1)};
        e[4] = {hi, lo}; n = 5;
      end
      4'd10: begin
        lo = memr({8'h00, b}); hi = memr({8'h00, 8'(b + 8'd1)});
        s = {1'b0, lo} + {1'b0, y};
        e[1] = {8'h00, b}; e[2] = {8'h00, 8'(b + 8'd1)}; e[3] = {hi, s[7:0]}; n = 4;
        if (s[8]) begin e[4] = {8'(hi + 8'd1), s[7:0]}; n = 5; end
      end
      4'd11: begin
        e[1] = pc + 16'd1; e[2] = {hi, lo}; e[3] = {hi, 8'(lo + 8'd1)}; n = 4;
        tl = memr(e[2]); th = memr(e[3]); epc = {th, tl};
      end
      default: begin n = 1; epc = pc; end
    endcase

    @(negedge clk);
    check(!rd_o && !done_o, "R11", "idle before start", {rd_o, done_o}, 0);
    start_i = 1'b1; mode_i = m; pc_i = pc; x_i = x; y_i = y;
    @(negedge clk);
    if (poke) begin
      start_i = 1'b1; mode_i = 4'd0; pc_i = 16'h0000;
    end else start_i = 1'b0;
    for (int k = 0; k <= n; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 1) start_i = 1'b0;
      if (k < n) begin
        check(rd_o === 1'b1 && done_o === 1'b0, "R1", "strobe in sequence", {rd_o, done_o}, 2'b10);
        check(addr_o === e[k], poke ? "R12" : tag(m), $sformatf("addr m%0d k%0d", m, k), addr_o, e[k]);
      end else begin
        check(rd_o === 1'b0 && done_o === 1'b1, "R11", "done pulse", {rd_o, done_o}, 2'b01);
        check(pc_o === epc, tag(m), $sformatf("final pc m%0d", m), pc_o, epc);
        check(operand_o === memr(e[n-1]), "R11", "operand", operand_o, memr(e[n-1]));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rd_o === 1'b0 && done_o === 1'b0, "R1", "reset state", {rd_o, done_o}, 0);
    rst_n = 1'b1;

    for (int m = 0; m < 12; m++)
      for (int pi = 0; pi < 3; pi++)
        for (int xi = 0; xi < 5; xi++) begin
          logic [15:0] pcs [3];
          logic [7:0]  xs [5];
          pcs = '{16'h8000, 16'h12FE, 16'hFFFF};
          xs  = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
          run_case(4'(m), pcs[pi], xs[xi], xs[4 - xi], 1'b0);
        end
    run_case(4'd14, 16'h3456, 8'h11, 8'h22, 1'b0);   // R2 unused code

    // R10 pointer at 0x02FF takes high byte from 0x0200
    pa[0] = 16'h4000; pd[0] = 8'hFF;
    pa[1] = 16'h4001; pd[1] = 8'h02;
    pa[2] = 16'h02FF; pd[2] = 8'h34;
    pa[3] = 16'h0200; pd[3] = 8'h12;
    pa[4] = 16'h0300; pd[4] = 8'h99;
    pn = 5;
    run_case(4'd11, 16'h4000, 8'h00, 8'h00, 1'b0);
    check(pc_o === 16'h1234, "R10", "page wrap target", pc_o, 16'h1234);

    // R7 forced crossing, R9 forced crossing, R8 pointer straddling 0xFF/0x00
    pa[0] = 16'h5000; pd[0] = 8'hF0;
    pa[1] = 16'h5001; pd[1] = 8'h20;
    pa[2] = 16'h6000; pd[2] = 8'h80;
    pa[3] = 16'h0080; pd[3] = 8'hF0;
    pa[4] = 16'h0081; pd[4] = 8'h30;
    pa[5] = 16'h7000; pd[5] = 8'hFE;
    pn = 6;
    run_case(4'd7, 16'h5000, 8'h20, 8'h00, 1'b0);
    run_case(4'd10, 16'h6000, 8'h00, 8'h20, 1'b0);
    run_case(4'd9, 16'h7000, 8'h01, 8'h00, 1'b0);
    run_case(4'd4, 16'h7000, 8'h05, 8'h00, 1'b0);

    // R12 start held high during a sequence
    run_case(4'd6, 16'h5000, 8'h00, 8'h00, 1'b1);
    run_case(4'd9, 16'h7000, 8'h03, 8'h00, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule